// File: doc/BRIEF.md
# Multidrop-Capable Asynchronous Serial Receiver

This block turns one asynchronous serial line into a stream of received characters that a host pulls from a small queue. A separate bit-rate generator supplies a strobe at sixteen times the bit rate. The line is oversampled at that strobe, and each bit is resolved by voting on samples taken near its centre. Characters carry eight data bits and an optional ninth bit. A completed character lands in a two-slot queue, together with its own ninth bit and stop-bit error. The host sees the oldest slot on its read outputs and pops it with a strobe.

On a multidrop bus, an address character is marked by a ninth bit of 1. With the address filter on and 9-bit mode selected, every character whose ninth bit is 0 is dropped before it reaches the queue. Once its own address has arrived, the host turns the filter off to take the data frames that follow. If a character finishes while the queue is full, it is lost and a sticky overrun flag rises. Reception then halts until the host drops the receive enable.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `rx_avail`, `overrun` and `irq` are all 0.
- R2: An 8-bit frame is one low start bit, eight data bits LSB first and one stop bit, each lasting 16 ticks. Once the frame is accepted, its data appears on `rd_data`, and `rd_bit9` reads 0 while `nine_bit_en` is 0.
- R3: With `nine_bit_en` = 1, nine bits are received after the start bit, LSB first. The last of them appears on `rd_bit9` and the first eight on `rd_data`.
- R4: Each bit value is the majority of three samples taken on consecutive ticks at its centre. A level inverted for a single tick near the centre of a data bit does not change the received value.
- R5: A low pulse on the idle line that is already high again by the centre of the would-be start bit is discarded and stores no character.
- R6: A frame whose stop bit is resolved as low is still stored, with `rd_ferr` = 1 for that entry. A frame with a high stop bit is stored with `rd_ferr` = 0.
- R7: With `addr_filter_en` = 1 and `nine_bit_en` = 1, only frames whose ninth bit is 1 are stored. After the filter is cleared, frames whose ninth bit is 0 are stored again.
- R8: `addr_filter_en` has no effect while `nine_bit_en` is 0.
- R9: The queue holds two characters in arrival order, each with its own ninth bit and error bit. The read outputs always show the oldest one, and a pulse on `rd_pop` advances to the next.
- R10: `rx_avail` is 1 exactly while the queue is non-empty, and `irq` = `rx_avail` AND `irq_en`.
- R11: When an accepted frame completes while the queue is full, that frame is dropped and `overrun` is set. While `overrun` is 1, no further frame is stored, even after entries have been popped.
- R12: Driving `rx_enable` low clears `overrun` and stops reception. Frames sent while it is low are not stored. After it returns high, reception resumes.
- R13: A `rd_pop` while the queue is empty has no effect on what is stored next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_in | input | 1 | Serial receive line, idle high |
| rx_enable | input | 1 | Continuous receive enable; low clears overrun and halts reception |
| nine_bit_en | input | 1 | Selects 9-bit frames |
| addr_filter_en | input | 1 | Drops frames with ninth bit 0 when 9-bit mode is on |
| irq_en | input | 1 | Receive interrupt enable |
| rd_pop | input | 1 | Pops the oldest queue entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_bit9 | output | 1 | Ninth bit of the oldest entry |
| rd_ferr | output | 1 | Stop-bit error of the oldest entry |
| rx_avail | output | 1 | Queue non-empty |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt request |

## Verification
A bit counter that slips by one tick moves every voting window off-centre. This shows at the ports as a shifted or corrupted `rd_data` on the first character that follows, about one frame time later. A wrong queue pointer or count shows as a stale head, or a wrong `rx_avail`, right after the next pop or the third character. A lost or stuck overrun flag is seen on `overrun`, and also through a character that should not have been stored but appears at the head. The bench therefore compares every entry field, `rx_avail` and `overrun` against its own queue model after each frame and each pop. It checks the interrupt relation on every clock.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic              ferr;
    logic              bit9;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  // Two-of-three vote on the samples taken around mid-bit
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Aligns the right-shifting register to {bit9, data}
  function automatic logic [DATA_W:0] align_frame(input logic [DATA_W:0] sh,
                                                  input logic nine);
    return nine ? sh : {1'b0, sh[DATA_W:1]};
  endfunction
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              nine,
  output logic              done,
  output logic [DATA_W:0]   word,
  output logic              ferr
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] MID1 = CW'(OSR/2);
  localparam logic [CW-1:0] MID2 = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam int IW = $clog2(DATA_W + 2);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} fr_state_t;

  fr_state_t        st;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [DATA_W:0]  sh;
  logic             v0, v1, prev, done_q, ferr_q;
  logic [CW-1:0]    cnt_nxt;
  logic [IW-1:0]    last_idx;
  logic             vote;

  assign cnt_nxt  = (cnt == LAST) ? '0 : cnt + 1'b1;
  assign last_idx = nine ? IW'(DATA_W) : IW'(DATA_W - 1);
  assign vote     = maj3(v0, v1, rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; sh <= '0;
      v0 <= 1'b1; v1 <= 1'b1; prev <= 1'b0; done_q <= 1'b0; ferr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        st <= S_IDLE; cnt <= '0; idx <= '0; prev <= 1'b0;
      end else if (tick) begin
        case (st)
          S_IDLE: begin
            prev <= rx_s;
            if (prev && !rx_s) begin
              st  <= S_START;
              cnt <= CW'(1);
            end
          end
          S_START: begin
            cnt <= cnt_nxt;
            if (cnt == MID && rx_s) begin
              st   <= S_IDLE;
              prev <= 1'b1;
            end else if (cnt == LAST) begin
              st  <= S_BITS;
              idx <= '0;
            end
          end
          S_BITS: begin
            cnt <= cnt_nxt;
            if (cnt == MID)  v0 <= rx_s;
            if (cnt == MID1) v1 <= rx_s;
            if (cnt == MID2) sh <= {vote, sh[DATA_W:1]};
            if (cnt == LAST) begin
              if (idx == last_idx) st <= S_STOP;
              else idx <= idx + 1'b1;
            end
          end
          default: begin
            cnt <= cnt_nxt;
            if (cnt == MID)  v0 <= rx_s;
            if (cnt == MID1) v1 <= rx_s;
            if (cnt == MID2) begin
              done_q <= 1'b1;
              ferr_q <= ~vote;
              prev   <= vote;
              st     <= S_IDLE;
            end
          end
        endcase
      end
    end
  end

  assign done = done_q;
  assign ferr = ferr_q;
  assign word = align_frame(sh, nine);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          pop_eff;

  assign pop_eff = pop && (count != '0);

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wptr] <= din;
        wptr      <= ptr_inc(wptr);
      end
      if (pop_eff) rptr <= ptr_inc(rptr);
      count <= count + CNTW'(push) - CNTW'(pop_eff);
    end
  end

  assign dout = mem[rptr];
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_in,
  input  logic              rx_enable,
  input  logic              nine_bit_en,
  input  logic              addr_filter_en,
  input  logic              irq_en,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              rx_avail,
  output logic              overrun,
  output logic              irq
);
  localparam int CNTW = $clog2(FIFO_DEPTH + 1);

  logic [1:0]       sync_q;
  logic             rx_s;
  logic             rx_active;
  logic             frame_done, frame_ferr;
  logic [DATA_W:0]  frame_word;
  logic             keep_frame, fifo_full, pop_ok, push_ok, ovr_evt;
  logic [CNTW-1:0]  fifo_cnt;
  rx_entry_t        new_entry, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_in};
  end
  assign rx_s      = sync_q[1];
  assign rx_active = rx_enable && !overrun;

  uart_rx_frame #(.OSR(OSR)) i_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .active(rx_active),
    .tick  (tick16),
    .rx_s  (rx_s),
    .nine  (nine_bit_en),
    .done  (frame_done),
    .word  (frame_word),
    .ferr  (frame_ferr)
  );

  assign keep_frame = !(addr_filter_en && nine_bit_en && !frame_word[DATA_W]);
  assign fifo_full  = (fifo_cnt == CNTW'(FIFO_DEPTH));
  assign pop_ok     = rd_pop && (fifo_cnt != '0);
  assign push_ok    = frame_done && keep_frame && !overrun && (!fifo_full || pop_ok);
  assign ovr_evt    = frame_done && keep_frame && !overrun && fifo_full && !pop_ok;

  assign new_entry = '{ferr: frame_ferr, bit9: frame_word[DATA_W],
                       data: frame_word[DATA_W-1:0]};

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) i_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push_ok),
    .din  (new_entry),
    .pop  (rd_pop),
    .dout (head),
    .count(fifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          overrun <= 1'b0;
    else if (!rx_enable) overrun <= 1'b0;
    else if (ovr_evt)    overrun <= 1'b1;
  end

  assign rd_data  = head.data;
  assign rd_bit9  = head.bit9;
  assign rd_ferr  = head.ferr;
  assign rx_avail = (fifo_cnt != '0);
  assign irq      = rx_avail && irq_en;
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int DEPTH = 2,
  parameter int CNTW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_enable,
  input logic            nine_bit_en,
  input logic            addr_filter_en,
  input logic            irq_en,
  input logic            rx_avail,
  input logic            overrun,
  input logic            irq,
  input logic            push_ok,
  input logic            frame_done,
  input logic            frame_bit9,
  input logic [CNTW-1:0] fifo_cnt
);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && fifo_cnt != '0));
  p_avail_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_avail == (fifo_cnt != '0));
  p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_enable) |=> overrun);
  p_no_store_ovr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !push_ok);
  p_ovr_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !overrun);
  p_addr_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && addr_filter_en && nine_bit_en) |-> frame_bit9);
  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNTW'(DEPTH));
  p_empty_pop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == '0 && !push_ok) |=> fifo_cnt == '0);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DEPTH(FIFO_DEPTH), .CNTW(CNTW)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_enable     (rx_enable),
  .nine_bit_en   (nine_bit_en),
  .addr_filter_en(addr_filter_en),
  .irq_en        (irq_en),
  .rx_avail      (rx_avail),
  .overrun       (overrun),
  .irq           (irq),
  .push_ok       (push_ok),
  .frame_done    (frame_done),
  .frame_bit9    (frame_word[uart_rx_pkg::DATA_W]),
  .fifo_cnt      (fifo_cnt)
);

// File: tb/test_uart_addr_rx.sv
module test_uart_addr_rx;
  localparam int DEPTH = 2;

  logic clk = 0, rst_n = 0;
  logic tick16;
  logic rx_in = 1, rx_enable = 0, nine_bit_en = 0, addr_filter_en = 0;
  logic irq_en = 0, rd_pop = 0;
  logic [7:0] rd_data;
  logic rd_bit9, rd_ferr, rx_avail, overrun, irq;
  logic [1:0] div = 0;

  int n_checks = 0, n_fail = 0;
  bit done_flag = 0;
  logic [9:0] q[$];   // {ferr, bit9, data}
  bit m_ovr = 0;

  always #5 clk = ~clk;
  always @(posedge clk) div <= div + 1'b1;
  assign tick16 = (div == 2'd3);

  uart_addr_rx i_uart_addr_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .rx_enable(rx_enable), .nine_bit_en(nine_bit_en),
    .addr_filter_en(addr_filter_en), .irq_en(irq_en), .rd_pop(rd_pop),
    .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
    .rx_avail(rx_avail), .overrun(overrun), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R10: interrupt relation compared on every clock
  always @(negedge clk) begin
    #1;
    if (rst_n && !done_flag)
      chk(irq === (rx_avail & irq_en), "R10 irq gate", irq, rx_avail & irq_en);
  end

  task automatic one_tick();
    do @(negedge clk); while (!tick16);
    @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    rx_in = v;
    for (int k = 0; k < n; k++) one_tick();
  endtask

  task automatic send(input logic [8:0] val, input logic stop_v, input int glitch);
    logic b9;
    hold(1'b0, 16);
    for (int i = 0; i < (nine_bit_en ? 9 : 8); i++) begin
      if (i == glitch) begin
        hold(val[i], 8); hold(~val[i], 1); hold(val[i], 7);
      end else hold(val[i], 16);
    end
    hold(stop_v, 16);
    hold(1'b1, 4);
    if (rx_enable && !m_ovr) begin
      b9 = nine_bit_en ? val[8] : 1'b0;
      if (!(addr_filter_en && nine_bit_en && !b9)) begin
        if (q.size() == DEPTH) m_ovr = 1;
        else q.push_back({~stop_v, b9, val[7:0]});
      end
    end
  endtask

  task automatic pop();
    @(negedge clk); rd_pop = 1;
    @(negedge clk); rd_pop = 0;
    if (q.size() != 0) void'(q.pop_front());
    @(negedge clk);
  endtask

  task automatic compare(input string tag);
    chk(rx_avail == (q.size() != 0), {tag, " avail"}, rx_avail, q.size() != 0);
    chk(overrun == m_ovr, {tag, " overrun"}, overrun, m_ovr);
    if (q.size() != 0)
      chk({rd_ferr, rd_bit9, rd_data} == q[0], {tag, " head"},
          {rd_ferr, rd_bit9, rd_data}, q[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!rx_avail && !overrun && !irq, "R1 reset", {rx_avail, overrun, irq}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    rx_enable = 1;
    hold(1'b1, 4);

    // R2: plain 8-bit frame, LSB first
    send(9'h0A5, 1'b1, -1); compare("R2 8-bit frame");
    // R10: interrupt follows enable
    chk(irq == 1'b0, "R10 irq masked", irq, 0);
    irq_en = 1; @(negedge clk);
    chk(irq == 1'b1, "R10 irq raised", irq, 1);
    pop(); compare("R10 avail clears on empty");

    // R13: pop on empty queue
    pop(); compare("R13 empty pop");
    send(9'h03C, 1'b1, -1); compare("R13 next store after empty pop");
    pop();

    // R4: one-tick glitch in a data bit
    send(9'h05A, 1'b1, 3); compare("R4 majority vote");
    pop();

    // R5: short low pulse is not a start bit
    hold(1'b0, 3); hold(1'b1, 40); compare("R5 false start");
    send(9'h081, 1'b1, -1); compare("R5 next frame aligned");
    pop();

    // R6 / R9: framing error entry followed by good entry
    send(9'h07E, 1'b0, -1); compare("R6 framing error stored");
    send(9'h011, 1'b1, -1); compare("R9 two entries head");
    pop(); compare("R9 second entry own status");
    pop();

    // R3: 9-bit frames
    nine_bit_en = 1;
    send(9'h12C, 1'b1, -1); compare("R3 ninth bit one");
    send(9'h0C3, 1'b1, 2);  compare("R3 queue head kept");
    pop(); compare("R3 ninth bit zero");
    pop();

    // R7: address filter
    addr_filter_en = 1;
    send(9'h044, 1'b1, -1); compare("R7 data frame dropped");
    send(9'h107, 1'b1, -1); compare("R7 address frame kept");
    addr_filter_en = 0;
    send(9'h099, 1'b1, -1); compare("R7 filter off");
    pop(); compare("R7 data after filter off");
    pop();

    // R8: filter ignored in 8-bit mode
    nine_bit_en = 0; addr_filter_en = 1;
    send(9'h066, 1'b1, -1); compare("R8 filter no effect");
    pop(); addr_filter_en = 0;

    // R11: overrun
    send(9'h001, 1'b1, -1);
    send(9'h002, 1'b1, -1);
    send(9'h003, 1'b1, -1); compare("R11 overrun set");
    pop(); compare("R11 after pop");
    send(9'h004, 1'b1, -1); compare("R11 no store while overrun");
    pop(); compare("R11 third frame dropped");

    // R12: clear receive enable
    rx_enable = 0; m_ovr = 0;
    repeat (3) @(negedge clk);
    compare("R12 overrun cleared");
    send(9'h0F0, 1'b1, -1); compare("R12 disabled no store");
    rx_enable = 1;
    hold(1'b1, 4);
    send(9'h055, 1'b1, -1); compare("R12 resumed");
    pop();

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule